// File: doc/BRIEF.md
# Edge/Level Interrupt Request Latch

This block captures interrupt requests for sixteen lines that belong to two cascaded 8-input controllers. Lines 0 to 7 belong to the first (primary) controller and lines 8 to 15 to the second. The block does not follow raw wire levels. Each line keeps an 8-bit saturating reference count. Each event on the event interface raises the count, lowers it, or does both in one step (a pulse). From the count movement and the line's trigger mode, the block decides whether the line's request bit is to be set or cleared.

The request register itself lives downstream. This block reports effects: one-cycle set and clear vectors, plus flags for saturation at either end of a count. A downstream register applies the set before the clear. A second port programs the trigger-mode register. It accepts either a whole byte for one controller, or one line at a time. Per controller, some bits are fixed at edge mode. The downstream register applies `(req | reqSet) & ~reqClr`.

Each controller reports separately whether it has finished initialization. Events aimed at a controller that is not ready are dropped.

Top module: `irqcap_top`

## Requirements
- R1: While reset is held, and in the first cycle after it, reqSet, reqClr, errHigh, errLow and cfgRefused are 0, trigSel is 0 (all lines edge mode) and every count is 0.
- R2: An accepted raise (evtCmd 0) adds one to the line's count. When the count goes from 0 to 1, bit evtLine of reqSet is 1 in the cycle after the event. At most one bit of reqSet is set per event.
- R3: A raise on a count already at 255 leaves the count at 255 and sets errHigh for one cycle.
- R4: An accepted drop (evtCmd 1) takes one from the count. A drop on a count of 0 leaves it at 0, sets errLow for one cycle, and neither sets nor clears the line.
- R5: On a level-mode line (trigSel bit 1), every raise or drop that leaves the count nonzero sets the line's reqSet bit.
- R6: A drop that takes the count from 1 to 0 sets the line's reqClr bit only on a level-mode line. An edge-mode line gives no clear.
- R7: A pulse (evtCmd 2) behaves as a raise followed by a drop in the same cycle. If the raise saturated, the drop is skipped. errHigh and errLow are never both set.
- R8: A byte write (cfgOp 1) stores cfgData ANDed with 8'hF8 for the primary controller (cfgLine bit 3 = 0), or with 8'hDE for the second controller (cfgLine bit 3 = 1). The result appears on trigSel the next cycle.
- R9: A single-line write (cfgOp 0, cfgData bit 0 = 1 for level) that asks for level mode on line 0, 1, 2, 8 or 13 is refused. cfgRefused is 1 the next cycle and trigSel is unchanged. Edge requests, and level requests on all other lines, are applied.
- R10: An event whose controller has chipReady low (bit 0 for lines 0-7, bit 1 for lines 8-15) gives no output and leaves the count unchanged.
- R11: evtCmd 3 is reserved. It gives no output and changes no count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| chipReady | input | 2 | Per-controller ready to accept events |
| evtValid | input | 1 | Event strobe, one per cycle |
| evtLine | input | 4 | Line number 0-15 |
| evtCmd | input | 2 | 0 raise, 1 drop, 2 pulse, 3 reserved |
| cfgValid | input | 1 | Trigger-mode write strobe |
| cfgOp | input | 1 | 0 single line, 1 whole byte |
| cfgLine | input | 4 | Line (single), bit 3 selects the controller (byte) |
| cfgData | input | 8 | Byte data, or bit 0 = level request |
| reqSet | output | 16 | One-cycle request-set effect per line |
| reqClr | output | 16 | One-cycle request-clear effect per line |
| errHigh | output | 1 | Raise hit a saturated count |
| errLow | output | 1 | Drop hit a zero count |
| cfgRefused | output | 1 | Level request on an edge-only line was refused |
| trigSel | output | 16 | Current trigger mode per line, 1 = level |

## Verification
A wrong count stays hidden until the next event on that line. It then shows up as a clear one event too early or too late, a missing set, or a saturation flag in the wrong place. For this reason, the bench drives a line to 255 and back and watches the exact event at which the clear and the low error appear. A wrong trigger-mode bit shows on trigSel one cycle after the write. It also shows through the set and clear pattern of the next event on that line. The checker ties errors and clears to the previous cycle's command and trigger state.

// File: rtl/irqcap_pkg.sv
`timescale 1ns/1ps
package irqcap_pkg;

  typedef enum logic [1:0] {
    CMD_RAISE = 2'd0,
    CMD_DROP  = 2'd1,
    CMD_PULSE = 2'd2,
    CMD_RSVD  = 2'd3
  } evtCmd_e;

  // Strobes from control to datapath for one cycle
  typedef struct packed {
    logic incStep;    // apply a raise step
    logic decStep;    // apply a drop step after the raise step
    logic pulseMode;  // drop is conditional on a clean raise
    logic cfgByteWr;  // byte write of trigger modes
    logic cfgLineWr;  // single-line trigger-mode write
    logic cfgLevel;   // requested mode for a single-line write
  } ctrlStrobe_t;

endpackage

// File: rtl/irqcap_ctrl.sv
`timescale 1ns/1ps
module irqcap_ctrl
  import irqcap_pkg::*;
#(
  parameter int NUM_CHIPS = 2,
  parameter int CHIP_PINS = 8,
  localparam int LINES  = NUM_CHIPS * CHIP_PINS,
  localparam int LINE_W = $clog2(LINES),
  localparam int PIN_W  = $clog2(CHIP_PINS),
  localparam int CHIP_W = LINE_W - PIN_W
) (
  input  logic [NUM_CHIPS-1:0] chipReady,
  input  logic                 evtValid,
  input  logic [LINE_W-1:0]    evtLine,
  input  logic [1:0]           evtCmd,
  input  logic                 cfgValid,
  input  logic                 cfgOp,
  input  logic [LINE_W-1:0]    cfgLine,
  input  logic                 cfgLevelBit,
  output ctrlStrobe_t          strobe,
  output logic [LINES-1:0]     evtSel,
  output logic [LINES-1:0]     cfgSel
);

  logic [CHIP_W-1:0] evtChip;
  logic [CHIP_W-1:0] cfgChip;
  logic              evtOk;
  evtCmd_e           cmd;

  assign evtChip = evtLine[LINE_W-1:PIN_W];
  assign cfgChip = cfgLine[LINE_W-1:PIN_W];
  assign cmd     = evtCmd_e'(evtCmd);

  always_comb begin
    strobe = '0;
    evtSel = '0;
    cfgSel = '0;
    evtOk  = evtValid && (32'(evtLine) < LINES) && chipReady[evtChip];

    if (evtOk) begin
      unique case (cmd)
        CMD_RAISE: strobe.incStep = 1'b1;
        CMD_DROP:  strobe.decStep = 1'b1;
        CMD_PULSE: begin
          strobe.incStep   = 1'b1;
          strobe.decStep   = 1'b1;
          strobe.pulseMode = 1'b1;
        end
        default: ;
      endcase
    end
    if (strobe.incStep || strobe.decStep)
      evtSel[evtLine] = 1'b1;

    if (cfgValid) begin
      if (cfgOp) begin
        strobe.cfgByteWr = 1'b1;
        for (int i = 0; i < LINES; i++)
          cfgSel[i] = (CHIP_W'(i / CHIP_PINS) == cfgChip);
      end else if (32'(cfgLine) < LINES) begin
        strobe.cfgLineWr = 1'b1;
        strobe.cfgLevel  = cfgLevelBit;
        cfgSel[cfgLine]  = 1'b1;
      end
    end
  end

endmodule

// File: rtl/irqcap_dpath.sv
`timescale 1ns/1ps
module irqcap_dpath
  import irqcap_pkg::*;
#(
  parameter int NUM_CHIPS = 2,
  parameter int CHIP_PINS = 8,
  parameter int CNT_W     = 8,
  localparam int LINES    = NUM_CHIPS * CHIP_PINS,
  parameter logic [LINES-1:0] TRIG_MASK = 16'hDEF8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobe_t          strobe,
  input  logic [LINES-1:0]     evtSel,
  input  logic [LINES-1:0]     cfgSel,
  input  logic [CHIP_PINS-1:0] cfgData,
  output logic [LINES-1:0]     reqSet,
  output logic [LINES-1:0]     reqClr,
  output logic                 errHigh,
  output logic                 errLow,
  output logic                 cfgRefused,
  output logic [LINES-1:0]     trigSel
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [LINES-1:0] setVec, clrVec, errHVec, errLVec, refVec;

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic [CNT_W-1:0] cnt, midCnt, newCnt;
    logic incDo, incSat, decDo, decSat, isLevel, trigBit;
    logic setL, clrL, refL;

    assign isLevel = trigBit;

    always_comb begin
      incDo  = evtSel[i] && strobe.incStep;
      incSat = (cnt == CNT_MAX);
      midCnt = (incDo && !incSat) ? cnt + CNT_ONE : cnt;
      decDo  = evtSel[i] && strobe.decStep && !(strobe.pulseMode && incDo && incSat);
      decSat = (midCnt == '0);
      newCnt = (decDo && !decSat) ? midCnt - CNT_ONE : midCnt;
      setL   = (incDo && ((cnt == '0 && midCnt == CNT_ONE) || (midCnt != '0 && isLevel)))
            || (decDo && newCnt != '0 && isLevel);
      clrL   = decDo && !decSat && midCnt == CNT_ONE && isLevel;
      refL   = strobe.cfgLineWr && cfgSel[i] && strobe.cfgLevel && !TRIG_MASK[i];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) cnt <= '0;
      else       cnt <= newCnt;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        trigBit <= 1'b0;
      else if (strobe.cfgByteWr && cfgSel[i])
        trigBit <= cfgData[i % CHIP_PINS] & TRIG_MASK[i];
      else if (strobe.cfgLineWr && cfgSel[i] && !refL)
        trigBit <= strobe.cfgLevel;
    end

    assign setVec[i]  = setL;
    assign clrVec[i]  = clrL;
    assign errHVec[i] = incDo && incSat;
    assign errLVec[i] = decDo && decSat;
    assign refVec[i]  = refL;
    assign trigSel[i] = trigBit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqSet     <= '0;
      reqClr     <= '0;
      errHigh    <= 1'b0;
      errLow     <= 1'b0;
      cfgRefused <= 1'b0;
    end else begin
      reqSet     <= setVec;
      reqClr     <= clrVec;
      errHigh    <= |errHVec;
      errLow     <= |errLVec;
      cfgRefused <= |refVec;
    end
  end

endmodule

// File: rtl/irqcap_top.sv
`timescale 1ns/1ps
module irqcap_top
  import irqcap_pkg::*;
#(
  parameter int NUM_CHIPS = 2,
  parameter int CHIP_PINS = 8,
  parameter int CNT_W     = 8,
  localparam int LINES    = NUM_CHIPS * CHIP_PINS,
  localparam int LINE_W   = $clog2(LINES),
  parameter logic [LINES-1:0] TRIG_MASK = 16'hDEF8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_CHIPS-1:0] chipReady,
  input  logic                 evtValid,
  input  logic [LINE_W-1:0]    evtLine,
  input  logic [1:0]           evtCmd,
  input  logic                 cfgValid,
  input  logic                 cfgOp,
  input  logic [LINE_W-1:0]    cfgLine,
  input  logic [CHIP_PINS-1:0] cfgData,
  output logic [LINES-1:0]     reqSet,
  output logic [LINES-1:0]     reqClr,
  output logic                 errHigh,
  output logic                 errLow,
  output logic                 cfgRefused,
  output logic [LINES-1:0]     trigSel
);

  ctrlStrobe_t      strobe;
  logic [LINES-1:0] evtSel;
  logic [LINES-1:0] cfgSel;

  irqcap_ctrl #(.NUM_CHIPS(NUM_CHIPS), .CHIP_PINS(CHIP_PINS)) u_ctrl (
    .chipReady(chipReady), .evtValid(evtValid), .evtLine(evtLine),
    .evtCmd(evtCmd), .cfgValid(cfgValid), .cfgOp(cfgOp), .cfgLine(cfgLine),
    .cfgLevelBit(cfgData[0]), .strobe(strobe), .evtSel(evtSel), .cfgSel(cfgSel)
  );

  irqcap_dpath #(.NUM_CHIPS(NUM_CHIPS), .CHIP_PINS(CHIP_PINS), .CNT_W(CNT_W),
                 .TRIG_MASK(TRIG_MASK)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .evtSel(evtSel), .cfgSel(cfgSel),
    .cfgData(cfgData), .reqSet(reqSet), .reqClr(reqClr), .errHigh(errHigh),
    .errLow(errLow), .cfgRefused(cfgRefused), .trigSel(trigSel)
  );

endmodule

// File: rtl/irqcap_chk.sv
`timescale 1ns/1ps
module irqcap_chk #(
  parameter int NUM_CHIPS = 2,
  parameter int CHIP_PINS = 8,
  localparam int LINES    = NUM_CHIPS * CHIP_PINS,
  localparam int LINE_W   = $clog2(LINES),
  localparam int PIN_W    = $clog2(CHIP_PINS),
  parameter logic [LINES-1:0] TRIG_MASK = 16'hDEF8
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [NUM_CHIPS-1:0] chipReady,
  input logic                 evtValid,
  input logic [LINE_W-1:0]    evtLine,
  input logic [1:0]           evtCmd,
  input logic                 cfgValid,
  input logic                 cfgOp,
  input logic [LINE_W-1:0]    cfgLine,
  input logic [CHIP_PINS-1:0] cfgData,
  input logic [LINES-1:0]     reqSet,
  input logic [LINES-1:0]     reqClr,
  input logic                 errHigh,
  input logic                 errLow,
  input logic                 cfgRefused,
  input logic [LINES-1:0]     trigSel
);

  logic quiet;
  logic notReady;
  assign quiet    = (reqSet == '0) && (reqClr == '0) && !errHigh && !errLow;
  assign notReady = !chipReady[evtLine[LINE_W-1:PIN_W]];

  assert_one_set_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(reqSet));

  assert_high_src_R3: assert property (@(posedge clk) disable iff (!rstN)
    errHigh |-> $past(evtValid && (evtCmd == 2'd0 || evtCmd == 2'd2)));

  assert_low_src_R4: assert property (@(posedge clk) disable iff (!rstN)
    errLow |-> $past(evtValid && (evtCmd == 2'd1 || evtCmd == 2'd2)));

  assert_clear_level_R6: assert property (@(posedge clk) disable iff (!rstN)
    (reqClr & ~$past(trigSel)) == '0);

  assert_single_err_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(errHigh && errLow));

  assert_mask_R8: assert property (@(posedge clk) disable iff (!rstN)
    (trigSel & ~TRIG_MASK) == '0);

  assert_refuse_keeps_R9: assert property (@(posedge clk) disable iff (!rstN)
    cfgRefused |-> $stable(trigSel));

  assert_not_ready_R10: assert property (@(posedge clk) disable iff (!rstN)
    (evtValid && notReady) |=> quiet);

  assert_reserved_R11: assert property (@(posedge clk) disable iff (!rstN)
    (evtValid && evtCmd == 2'd3) |=> quiet);

endmodule

bind irqcap_top irqcap_chk #(.NUM_CHIPS(NUM_CHIPS), .CHIP_PINS(CHIP_PINS),
                             .TRIG_MASK(TRIG_MASK)) u_chk (.*);

// File: tb/sim_irqcap_top.sv
`timescale 1ns/1ps
module sim_irqcap_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  chipReady = 2'b00;
  logic        evtValid = 1'b0;
  logic [3:0]  evtLine = '0;
  logic [1:0]  evtCmd = '0;
  logic        cfgValid = 1'b0;
  logic        cfgOp = 1'b0;
  logic [3:0]  cfgLine = '0;
  logic [7:0]  cfgData = '0;
  logic [15:0] reqSet, reqClr, trigSel;
  logic        errHigh, errLow, cfgRefused;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irqcap_top u0 (.*);

  // Row: {cmd[1:0], line[3:0], expSet, expClr, expErrHigh, expErrLow}
  // Trigger modes for the walk: 16'hDEF8 (level except lines 0,1,2,8,13)
  localparam logic [9:0] VECS [18] = '{
    {2'd0, 4'd0,  4'b1000},  // edge 0->1 sets
    {2'd0, 4'd0,  4'b0000},  // edge 1->2 quiet
    {2'd1, 4'd0,  4'b0000},  // edge 2->1 quiet
    {2'd1, 4'd0,  4'b0000},  // edge 1->0 no clear (R6)
    {2'd1, 4'd0,  4'b0001},  // drop at 0 (R4)
    {2'd0, 4'd3,  4'b1000},  // level 0->1
    {2'd0, 4'd3,  4'b1000},  // level 1->2 sets (R5)
    {2'd1, 4'd3,  4'b1000},  // level 2->1 sets (R5)
    {2'd1, 4'd3,  4'b0100},  // level 1->0 clears (R6)
    {2'd2, 4'd8,  4'b1000},  // pulse edge
    {2'd2, 4'd9,  4'b1100},  // pulse level from 0: set then clear
    {2'd0, 4'd9,  4'b1000},
    {2'd2, 4'd9,  4'b1000},  // pulse level from 1
    {2'd1, 4'd9,  4'b0100},
    {2'd3, 4'd9,  4'b0000},  // reserved (R11)
    {2'd1, 4'd9,  4'b0001},  // count still 0 after reserved (R11)
    {2'd2, 4'd13, 4'b1000},
    {2'd1, 4'd13, 4'b0001}
  };

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic string tagFor(logic [1:0] cmd);
    case (cmd)
      2'd0: return "R2";
      2'd1: return "R4";
      2'd2: return "R7";
      default: return "R11";
    endcase
  endfunction

  task automatic doEvt(logic [1:0] cmd, logic [3:0] line);
    @(negedge clk);
    evtValid = 1'b1; evtCmd = cmd; evtLine = line;
    @(negedge clk);
    evtValid = 1'b0;
  endtask

  task automatic evtCheck(string tag, logic [1:0] cmd, logic [3:0] line,
                          bit s, bit c, bit eh, bit el);
    logic [15:0] oneHot;
    oneHot = 16'(1) << line;
    doEvt(cmd, line);
    check(tag, {reqSet, reqClr, errHigh, errLow},
          {(s ? oneHot : 16'h0), (c ? oneHot : 16'h0), eh, el});
  endtask

  task automatic doCfg(bit op, logic [3:0] line, logic [7:0] data);
    @(negedge clk);
    cfgValid = 1'b1; cfgOp = op; cfgLine = line; cfgData = data;
    @(negedge clk);
    cfgValid = 1'b0;
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 during reset", {reqSet, reqClr, errHigh, errLow, cfgRefused, trigSel},
          '0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after reset", {reqSet, reqClr, errHigh, errLow, cfgRefused, trigSel},
          '0);
    chipReady = 2'b11;

    // R8: byte writes are masked per controller
    doCfg(1'b1, 4'd0, 8'hFF);
    check("R8 primary byte", trigSel, 16'h00F8);
    doCfg(1'b1, 4'd8, 8'hFF);
    check("R8 second byte", trigSel, 16'hDEF8);

    // Vector walk
    for (int k = 0; k < 18; k++) begin
      logic [9:0] v;
      v = VECS[k];
      evtCheck(tagFor(v[9:8]), v[9:8], v[7:4], v[3], v[2], v[1], v[0]);
    end

    // R3 and R7: saturation on level line 4
    evtCheck("R2 sat start", 2'd0, 4'd4, 1, 0, 0, 0);
    for (int i = 1; i < 255; i++)
      evtCheck("R5 climb", 2'd0, 4'd4, 1, 0, 0, 0);
    evtCheck("R3 raise at max", 2'd0, 4'd4, 1, 0, 1, 0);
    evtCheck("R7 pulse at max skips drop", 2'd2, 4'd4, 1, 0, 1, 0);
    for (int i = 1; i < 255; i++)
      evtCheck("R5 descend", 2'd1, 4'd4, 1, 0, 0, 0);
    evtCheck("R6 level last drop clears", 2'd1, 4'd4, 0, 1, 0, 0);
    evtCheck("R4 drop at zero after sat", 2'd1, 4'd4, 0, 0, 0, 1);

    // R9: single-line trigger writes
    doCfg(1'b0, 4'd1, 8'h01);
    check("R9 line 1 refused flag", cfgRefused, 1);
    check("R9 line 1 unchanged", trigSel, 16'hDEF8);
    doCfg(1'b0, 4'd13, 8'h01);
    check("R9 line 13 refused", {cfgRefused, trigSel}, {1'b1, 16'hDEF8});
    doCfg(1'b0, 4'd3, 8'h00);
    check("R9 edge on line 3", {cfgRefused, trigSel}, {1'b0, 16'hDEF0});
    evtCheck("R6 edge line 3 set", 2'd0, 4'd3, 1, 0, 0, 0);
    evtCheck("R6 edge line 3 no clear", 2'd1, 4'd3, 0, 0, 0, 0);
    doCfg(1'b0, 4'd3, 8'h01);
    check("R9 level on line 3", {cfgRefused, trigSel}, {1'b0, 16'hDEF8});

    // R10: second controller not ready
    chipReady = 2'b01;
    evtCheck("R10 ignored raise", 2'd0, 4'd10, 0, 0, 0, 0);
    evtCheck("R10 primary still works", 2'd0, 4'd5, 1, 0, 0, 0);
    chipReady = 2'b11;
    evtCheck("R10 count unchanged", 2'd1, 4'd10, 0, 0, 0, 1);
    evtCheck("R6 line 5 release", 2'd1, 4'd5, 0, 1, 0, 0);

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    #750000;
    if (!done) begin
      done = 1'b1;
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

endmodule